// File: doc/BRIEF.md
# Control/Status Register Access Unit

This unit carries out the register-access operations of a processor's control and status register space against a small machine-level register set. The set has a status word, an interrupt-enable word, a scratch word, an interrupt-pending word and a 64-bit retired-instruction counter. The counter is exposed as two read-only 32-bit halves. Each operation reads the old register value for the destination register and may then write, set bits in or clear bits in the selected register. The write operand is either the source-register value or a zero-extended 5-bit immediate.

The pipeline presents one operation per cycle on a valid strobe. The operation carries the 3-bit function code, the 12-bit register address, the source value, the immediate, and two flags that mark the destination and source registers as the zero register. The answer arrives one cycle later. It gives the old value, whether that value is to be written back, and an illegal-operation flag. An external supervisor-level interrupt line is merged into one pending bit when that bit is read. Read-modify-write updates never see the external line. A retire pulse advances the counter.

Top module: `csr_access_unit`

## Requirements
- R1: Function code 001 (register form) or 101 (immediate form) returns the register's prior value and replaces the register contents with the operand, subject to the writable mask of R12.
- R2: Function code 010 or 110 returns the prior value and ORs the operand into the register. When the operand comes from the zero register (register form) or is an immediate of 0, nothing is written, and the operation is a plain read.
- R3: Function code 011 or 111 returns the prior value and clears every register bit where the operand has a 1. The zero-operand case of R2 applies here as well.
- R4: Immediate forms (function code bit 2 set) zero-extend the 5-bit immediate to form the operand and ignore the source value.
- R5: A write operation (001/101) with the destination-zero flag set still writes the register. Its response has `rsp_wb` low and `rsp_rdata` zero.
- R6: A read of the pending word (0x344) returns bit 9 as the OR of the stored software bit and the external interrupt line as sampled in the operation cycle.
- R7: Set and clear operations on the pending word start from the stored software bits only. An external line that is high does not become stored state.
- R8: Addresses with bits [11:10] = 11 are read-only. Any operation there that writes is illegal and changes nothing. Set or clear with a zero operand there is a legal read.
- R9: An address outside the implemented set is illegal. Its response has `rsp_wb` low and it changes no state.
- R10: Function codes 000 and 100 are illegal and change no state.
- R11: The counter rises by one in each cycle that `retire` is high. Its low half reads at 0xC02 and its high half at 0xC82. A read returns the value from before that cycle's increment.
- R12: After reset all registers read zero. Writable bits are: status (0x300) mask 0x0000188A; enable (0x304) mask 0x00000AAA; pending (0x344) software mask 0x00000222; scratch (0x340) all bits. Bits outside the mask always read 0.
- R13: `rsp_valid` is high exactly one cycle after `op_valid`. `rsp_illegal` and `rsp_wb` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_funct3 | input | 3 | Function code |
| op_addr | input | 12 | Register address |
| op_src | input | 32 | Source register value |
| op_imm | input | 5 | Immediate operand |
| op_rd_zero | input | 1 | Destination is the zero register |
| op_rs1_zero | input | 1 | Source is the zero register |
| ext_sup_irq | input | 1 | External supervisor interrupt line |
| retire | input | 1 | One instruction retired this cycle |
| rsp_valid | output | 1 | Response for last cycle's operation |
| rsp_wb | output | 1 | Write rsp_rdata to the destination |
| rsp_rdata | output | 32 | Prior register value |
| rsp_illegal | output | 1 | Operation raised illegal-instruction |

## Verification
Two pairs of events can land in the same cycle. A counter read can coincide with a retire pulse, and a pending-word update can coincide with the external line being high. The bench drives both pairs on purpose and then keeps `retire` and the external line random beside a random stream of operations. A behavioural model decides each cycle's expected response: the counter value from before the increment, and a pending bit 9 that shows the line for this read only and is gone once the line drops. The bench compares the model's answer with the design on every clock.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int IMM_W    = 5;
    localparam int EXT_BIT  = 9;

    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
    localparam logic [ADDR_W-1:0] A_IENAB   = 12'h304;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
    localparam logic [ADDR_W-1:0] A_IPEND   = 12'h344;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'hC02;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'hC82;

    typedef enum logic [1:0] {
        CSR_OP_BAD   = 2'd0,
        CSR_OP_WRITE = 2'd1,
        CSR_OP_SET   = 2'd2,
        CSR_OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_STATUS  = 3'd1,
        SEL_IENAB   = 3'd2,
        SEL_SCRATCH = 3'd3,
        SEL_IPEND   = 3'd4,
        SEL_CNT_LO  = 3'd5,
        SEL_CNT_HI  = 3'd6
    } csr_sel_e;

    typedef struct packed {
        logic              valid;
        csr_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] operand;
        logic              writes;
        logic              reads;
    } csr_req_t;

    function automatic csr_sel_e csr_lookup(input logic [ADDR_W-1:0] a);
        case (a)
            A_STATUS:  return SEL_STATUS;
            A_IENAB:   return SEL_IENAB;
            A_SCRATCH: return SEL_SCRATCH;
            A_IPEND:   return SEL_IPEND;
            A_CNT_LO:  return SEL_CNT_LO;
            A_CNT_HI:  return SEL_CNT_HI;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] csr_wmask(input csr_sel_e s);
        case (s)
            SEL_STATUS:  return 32'h0000_188A;
            SEL_IENAB:   return 32'h0000_0AAA;
            SEL_SCRATCH: return '1;
            SEL_IPEND:   return 32'h0000_0222;
            default:     return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] csr_modify(input csr_op_e op,
                                                     input logic [DATA_W-1:0] base,
                                                     input logic [DATA_W-1:0] opnd);
        case (op)
            CSR_OP_WRITE: return opnd;
            CSR_OP_SET:   return base | opnd;
            CSR_OP_CLEAR: return base & ~opnd;
            default:      return base;
        endcase
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_unit_pkg::*;
(
    input  logic              in_valid,
    input  logic [2:0]        in_funct3,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_src,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic              in_rd_zero,
    input  logic              in_rs1_zero,
    output csr_req_t          req
);
    logic    use_imm;
    logic    zero_opnd;
    csr_op_e kind;

    assign use_imm   = in_funct3[2];
    assign kind      = csr_op_e'(in_funct3[1:0]);
    assign zero_opnd = use_imm ? (in_imm == '0) : in_rs1_zero;

    always_comb begin
        req.valid   = in_valid;
        req.op      = kind;
        req.addr    = in_addr;
        req.operand = use_imm ? {{(DATA_W-IMM_W){1'b0}}, in_imm} : in_src;
        req.writes  = (kind == CSR_OP_WRITE) || ((kind != CSR_OP_BAD) && !zero_opnd);
        req.reads   = !((kind == CSR_OP_WRITE) && in_rd_zero);
    end
endmodule

// File: rtl/csr_retire_ctr.sv
module csr_retire_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (retire)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_unit_pkg::*;
#(
    parameter int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  csr_req_t          req,
    input  logic              ext_irq,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rd_value,
    output logic              fault,
    output logic              wb
);
    localparam int NUM_RW = 4;

    csr_sel_e          sel;
    logic              ro;
    logic              commit;
    logic [DATA_W-1:0] soft_val;
    logic [DATA_W-1:0] next_val;
    logic [DATA_W-1:0] ext_bits;
    logic [DATA_W-1:0] rw_q [NUM_RW];

    assign sel    = csr_lookup(req.addr);
    assign ro     = (req.addr[ADDR_W-1:ADDR_W-2] == 2'b11);
    assign fault  = req.valid && ((req.op == CSR_OP_BAD) || (sel == SEL_NONE) || (ro && req.writes));
    assign commit = req.valid && !fault && req.writes && !ro;
    assign wb     = req.valid && !fault && req.reads;

    always_comb begin
        case (sel)
            SEL_STATUS:  soft_val = rw_q[0];
            SEL_IENAB:   soft_val = rw_q[1];
            SEL_SCRATCH: soft_val = rw_q[2];
            SEL_IPEND:   soft_val = rw_q[3];
            SEL_CNT_LO:  soft_val = count[DATA_W-1:0];
            SEL_CNT_HI:  soft_val = count[CNT_W-1:DATA_W];
            default:     soft_val = '0;
        endcase
    end

    // the external line joins the read path only, never the update base
    assign ext_bits = (sel == SEL_IPEND) ? (DATA_W'(ext_irq) << EXT_BIT) : '0;
    assign rd_value = soft_val | ext_bits;
    assign next_val = csr_modify(req.op, soft_val, req.operand);

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        localparam csr_sel_e MY_SEL = csr_sel_e'(g + 1);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (commit && (sel == MY_SEL))
                q <= next_val & csr_wmask(MY_SEL);
        end
        assign rw_q[g] = q;
    end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_unit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_funct3,
    input  logic [11:0] op_addr,
    input  logic [31:0] op_src,
    input  logic [4:0]  op_imm,
    input  logic        op_rd_zero,
    input  logic        op_rs1_zero,
    input  logic        ext_sup_irq,
    input  logic        retire,
    output logic        rsp_valid,
    output logic        rsp_wb,
    output logic [31:0] rsp_rdata,
    output logic        rsp_illegal
);
    localparam int CNT_W = 2 * DATA_W;

    csr_req_t          req;
    logic [CNT_W-1:0]  retired_count;
    logic [DATA_W-1:0] rd_value;
    logic              fault;
    logic              wb;

    csr_decode u_dec (
        .in_valid    (op_valid),
        .in_funct3   (op_funct3),
        .in_addr     (op_addr),
        .in_src      (op_src),
        .in_imm      (op_imm),
        .in_rd_zero  (op_rd_zero),
        .in_rs1_zero (op_rs1_zero),
        .req         (req)
    );

    csr_retire_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .retire (retire),
        .count  (retired_count)
    );

    csr_regfile #(.CNT_W(CNT_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .ext_irq  (ext_sup_irq),
        .count    (retired_count),
        .rd_value (rd_value),
        .fault    (fault),
        .wb       (wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_wb      <= 1'b0;
            rsp_rdata   <= '0;
            rsp_illegal <= 1'b0;
        end else begin
            rsp_valid   <= op_valid;
            rsp_wb      <= wb;
            rsp_rdata   <= wb ? rd_value : '0;
            rsp_illegal <= fault;
        end
    end
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [2:0]  op_funct3,
    input logic [11:0] op_addr,
    input logic        op_rd_zero,
    input logic        ext_sup_irq,
    input logic        retire,
    input logic        rsp_valid,
    input logic        rsp_wb,
    input logic [31:0] rsp_rdata,
    input logic        rsp_illegal,
    input logic [63:0] retired_count
);
    assert_rsp_timing_R13: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(op_valid)));

    assert_illegal_no_wb_R13: assert property (@(posedge clk) disable iff (rst)
        !(rsp_illegal && rsp_wb));

    assert_bad_funct_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && ($past(op_funct3[1:0]) == 2'b00)) |-> rsp_illegal);

    assert_write_rd_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_valid) && ($past(op_funct3[1:0]) == 2'b01) && $past(op_rd_zero))
        |-> (!rsp_wb && (rsp_rdata == 32'h0)));

    assert_pending_ext_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_wb && ($past(op_addr) == 12'h344) && $past(ext_sup_irq)) |-> rsp_rdata[9]);

    assert_counter_step_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (retired_count == $past(retired_count) + 64'($past(retire))));
endmodule

bind csr_access_unit csr_access_unit_chk u_chk (.*);

// File: tb/tb_csr_access_unit.sv
module tb_csr_access_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_funct3 = '0;
    logic [11:0] op_addr = '0;
    logic [31:0] op_src = '0;
    logic [4:0]  op_imm = '0;
    logic        op_rd_zero = 1'b0;
    logic        op_rs1_zero = 1'b0;
    logic        ext_sup_irq = 1'b0;
    logic        retire = 1'b0;
    logic        rsp_valid, rsp_wb, rsp_illegal;
    logic [31:0] rsp_rdata;

    always #4 clk = ~clk;

    csr_access_unit dut (.*);

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string cur_tag = "R12";
    string tag_q = "R12";

    // behavioural reference state
    logic [31:0] m_status, m_enab, m_scr, m_pend;
    longint unsigned m_cnt;
    logic        e_valid, e_wb, e_ill;
    logic [31:0] e_data;

    always @(posedge clk) begin
        if (rst) begin
            m_status = 0; m_enab = 0; m_scr = 0; m_pend = 0; m_cnt = 0;
            e_valid = 0; e_wb = 0; e_ill = 0; e_data = 0;
        end else begin
            logic [31:0] opnd, cur, nv, msk;
            logic nomask, writes, known, ro;
            int kind;
            tag_q = cur_tag;
            e_valid = op_valid; e_wb = 0; e_ill = 0; e_data = 0;
            if (op_valid) begin
                opnd   = op_funct3[2] ? 32'(op_imm) : op_src;
                nomask = op_funct3[2] ? (op_imm == 0) : op_rs1_zero;
                kind   = int'(op_funct3[1:0]);
                writes = (kind == 1) || (kind != 0 && !nomask);
                ro     = op_addr >= 12'hC00;
                known  = 1; cur = 0; msk = 0;
                case (op_addr)
                    12'h300: begin cur = m_status; msk = 32'h188A; end
                    12'h304: begin cur = m_enab;   msk = 32'hAAA;  end
                    12'h340: begin cur = m_scr;    msk = 32'hFFFF_FFFF; end
                    12'h344: begin cur = m_pend;   msk = 32'h222;  end
                    12'hC02: cur = m_cnt[31:0];
                    12'hC82: cur = m_cnt[63:32];
                    default: known = 0;
                endcase
                if (kind == 0 || !known || (ro && writes)) e_ill = 1;
                else begin
                    if (!(kind == 1 && op_rd_zero)) begin
                        e_wb = 1;
                        e_data = cur | ((op_addr == 12'h344 && ext_sup_irq) ? 32'h200 : 0);
                    end
                    if (writes && !ro) begin
                        nv = (kind == 1) ? opnd : (kind == 2) ? (cur | opnd) : (cur & ~opnd);
                        nv = nv & msk;
                        case (op_addr)
                            12'h300: m_status = nv;
                            12'h304: m_enab = nv;
                            12'h340: m_scr = nv;
                            default: m_pend = nv;
                        endcase
                    end
                end
            end
            if (retire) m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (rsp_valid !== e_valid || rsp_wb !== e_wb || rsp_illegal !== e_ill || rsp_rdata !== e_data) begin
                n_fail++;
                $display("FAIL %s: actual valid=%0b wb=%0b ill=%0b data=%h expected valid=%0b wb=%0b ill=%0b data=%h",
                         tag_q, rsp_valid, rsp_wb, rsp_illegal, rsp_rdata, e_valid, e_wb, e_ill, e_data);
            end
        end
    end

    task automatic issue(input logic [2:0] f3, input logic [11:0] a, input logic [31:0] s,
                         input logic [4:0] imm, input bit rdz, input bit rsz, input string tag);
        cur_tag = tag;
        op_valid = 1; op_funct3 = f3; op_addr = a; op_src = s; op_imm = imm;
        op_rd_zero = rdz; op_rs1_zero = rsz;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        issue(3'b010, a, 32'h0, 5'h0, 0, 1, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12: reset values
        rd(12'h300, "R12"); rd(12'h304, "R12"); rd(12'h340, "R12"); rd(12'h344, "R12");
        rd(12'hC02, "R12"); rd(12'hC82, "R12");
        // R1: write returns old, stores new
        issue(3'b001, 12'h340, 32'hDEADBEEF, 0, 0, 0, "R1");
        issue(3'b001, 12'h340, 32'h12345678, 0, 0, 0, "R1");
        rd(12'h340, "R1");
        // R12: writable masks
        issue(3'b001, 12'h300, 32'hFFFF_FFFF, 0, 0, 0, "R12");
        rd(12'h300, "R12");
        // R2 / R3 register forms
        issue(3'b010, 12'h304, 32'h0000_00F0, 0, 0, 0, "R2");
        issue(3'b011, 12'h304, 32'h0000_0020, 0, 0, 0, "R3");
        rd(12'h304, "R2");
        // R4: immediate forms, source value ignored
        issue(3'b101, 12'h340, 32'hFFFF_0000, 5'h1F, 0, 0, "R4");
        issue(3'b111, 12'h340, 32'hFFFF_FFFF, 5'h05, 0, 0, "R4");
        issue(3'b110, 12'h340, 32'h0, 5'h10, 0, 1, "R4");
        issue(3'b110, 12'h340, 32'hFFFF_FFFF, 5'h00, 0, 0, "R2");
        rd(12'h340, "R4");
        // R5: write with destination zero
        issue(3'b001, 12'h340, 32'hCAFE_F00D, 0, 1, 0, "R5");
        rd(12'h340, "R5");
        // R6 / R7: external line vs software bit
        ext_sup_irq = 1;
        rd(12'h344, "R6");
        issue(3'b010, 12'h344, 32'h0000_0002, 0, 0, 0, "R7");
        issue(3'b011, 12'h344, 32'h0000_0020, 0, 0, 0, "R7");
        ext_sup_irq = 0;
        rd(12'h344, "R7");
        issue(3'b001, 12'h344, 32'h0000_0200, 0, 0, 0, "R6");
        ext_sup_irq = 1;
        rd(12'h344, "R6");
        ext_sup_irq = 0;
        // R8: read-only space
        issue(3'b001, 12'hC02, 32'h1, 0, 0, 0, "R8");
        issue(3'b001, 12'hC02, 32'h1, 0, 1, 0, "R8");
        issue(3'b010, 12'hC02, 32'h0, 0, 0, 0, "R8");
        issue(3'b110, 12'hC82, 32'h0, 5'h3, 0, 0, "R8");
        issue(3'b111, 12'hC02, 32'h0, 5'h0, 0, 0, "R8");
        // R9: unimplemented address
        issue(3'b001, 12'h123, 32'h5555_5555, 0, 0, 0, "R9");
        issue(3'b010, 12'h7C0, 32'h0, 0, 0, 1, "R9");
        rd(12'h340, "R9");
        // R10: bad function codes
        issue(3'b000, 12'h340, 32'h0, 0, 0, 0, "R10");
        issue(3'b100, 12'h340, 32'h0, 5'h7, 0, 0, "R10");
        rd(12'h340, "R10");
        // R11: counter, with retire in the read cycle
        retire = 1;
        repeat (5) @(negedge clk);
        rd(12'hC02, "R11");
        rd(12'hC02, "R11");
        retire = 0;
        rd(12'hC02, "R11");
        rd(12'hC82, "R11");
        // R13: back-to-back then idle
        issue(3'b001, 12'h304, 32'h0000_0FFF, 0, 0, 0, "R13");
        @(negedge clk);
        rd(12'h304, "R13");
        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            logic [11:0] alist [8];
            alist = '{12'h300, 12'h304, 12'h340, 12'h344, 12'hC02, 12'hC82, 12'h123, 12'hFC0};
            retire = 1'($urandom);
            ext_sup_irq = 1'($urandom);
            if ($urandom % 4 == 0) begin
                cur_tag = "R13";
                @(negedge clk);
            end else begin
                issue(3'($urandom), alist[$urandom % 8], $urandom, 5'($urandom),
                      1'($urandom), ($urandom % 3 == 0), "R1");
            end
        end
        retire = 0; ext_sup_irq = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule